// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block takes single read or write requests from a processor core and runs them as complete cycles on an external memory bus. The high byte of the request address is compared against programmable bank start values. The block then raises one bank select, which serves as an early hint that a cycle may follow. After that it drives a read or write strobe until the access can finish. Two sources stretch the strobe phase: a programmed wait count for each bank, and an external acknowledge input that a slow device can hold low.

For page-mode DRAM, the block raises a page flag whenever an access lands in a different page from the access before it. The page size is a programmable power of two. An external float request releases the address, select, strobe and data drivers at once and freezes the access in progress. Once the request is withdrawn, the acknowledge input must be seen high before the strobe phase starts again with a full wait count. A core word sits in the top bits of the wider external data bus.

Top module: `extmem_ctrl`

## Requirements
- R1: After reset no select, strobe, data enable, page flag or core ready is asserted, and the bus drivers are enabled while `tri_req` is low.
- R2: A configuration write with `cfg_addr` = i (i below NUM_BANKS) stores bits [WAIT_W-1:0] as bank i's wait count and bits [HI_W+7:8] as bank i's start value. The access raises `mem_sel` bit b, where b is the highest-numbered bank whose start is at most the top HI_W address bits. If no bank qualifies, no select is raised and zero waits apply.
- R3: An accepted request first spends exactly one cycle with its select raised and no strobe. Strobes begin in the next cycle.
- R4: With acknowledge high, the strobe stays high for the bank's wait count plus one cycle. `core_ready` pulses high for one cycle in the cycle that follows.
- R5: The access finishes only in a strobe cycle that is past the programmed waits and has `mem_ack` high. Each cycle of acknowledge low at that point lengthens the strobe by one cycle.
- R6: A configuration write with `cfg_addr` = NUM_BANKS sets the page shift from bits [4:0]; the page number is the address shifted right by that amount. `mem_page` is high for the whole access when its page differs from the page of the previous access, or when no access has occurred since reset.
- R7: While `tri_req` is high, `mem_addr_oe`, `mem_dout_en`, `mem_rd` and `mem_wr` are low, and an access in progress does not complete.
- R8: After `tri_req` falls, the suspended access waits for one cycle with `mem_ack` high. It then repeats the full strobe phase of wait count plus one cycle.
- R9: A write drives the core word on `mem_dout` bits [BUS_W-1:BUS_W-DATA_W] with the lower bits zero. A read returns `mem_din` bits [BUS_W-1:BUS_W-DATA_W] on `core_rdata` along with `core_ready`.
- R10: `mem_rd` and `mem_wr` are never high together. `mem_dout_en` is high only while the write strobe is high.
- R11: A request held high during its own ready cycle is not accepted a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_req | input | 1 | Core access request, held until ready |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Access address |
| core_wdata | input | DATA_W | Write word |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | DATA_W | Read word, valid with ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration entry: bank index, or NUM_BANKS for page shift |
| cfg_wdata | input | HI_W+8 | Configuration value |
| mem_addr | output | ADDR_W | External address |
| mem_addr_oe | output | 1 | Enable for address, select, strobe and page drivers |
| mem_sel | output | NUM_BANKS | One-hot bank selects |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_dout | output | BUS_W | External write data |
| mem_dout_en | output | 1 | Data driver enable |
| mem_din | input | BUS_W | External read data |
| mem_ack | input | 1 | Acknowledge; low adds wait cycles |
| mem_page | output | 1 | Page-crossing flag |
| tri_req | input | 1 | Float request |

## Verification
Two functions can fall on the same cycle. A float request can arrive in a strobe cycle that would otherwise complete the access, and the acknowledge input decides both whether an access ends and whether a suspended access may resume. The bench raises `tri_req` in the middle of a write strobe. It holds acknowledge low after the release, then grants it for one cycle. Throughout, it checks that the drivers drop in the same cycle, that no ready appears while floated or before the acknowledge, and that the strobe phase afterwards has the full length again.

// File: rtl/extmem_ctrl.sv
module extmem_ctrl #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 32,
  parameter int BUS_W     = 48,
  parameter int NUM_BANKS = 4,
  parameter int HI_W      = 8,
  parameter int WAIT_W    = 4,
  parameter int CFG_AW    = $clog2(NUM_BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [HI_W+7:0]   cfg_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_addr_oe,
  output logic [NUM_BANKS-1:0] mem_sel,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [BUS_W-1:0]  mem_dout,
  output logic              mem_dout_en,
  input  logic [BUS_W-1:0]  mem_din,
  input  logic              mem_ack,
  output logic              mem_page,
  input  logic              tri_req
);
  localparam int LANE = BUS_W - DATA_W;
  localparam int SPAN = (2 ** HI_W) / NUM_BANKS;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t                  st;
  logic [WAIT_W-1:0]    waits [NUM_BANKS];
  logic [HI_W-1:0]      start [NUM_BANKS];
  logic [4:0]           page_sh;
  logic [NUM_BANKS-1:0] sel_q, dec;
  logic [ADDR_W-1:0]    addr_q, page_now, last_pg;
  logic [DATA_W-1:0]    wdata_q, rdata_q;
  logic [WAIT_W-1:0]    cnt, wsel;
  logic                 we_q, ready_q, pg_valid, cross_q, busy;
  logic                 cfg_unused;

  assign cfg_unused = ^{cfg_wdata[7:5], mem_din[LANE-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BANKS; i++) begin
        waits[i] <= '1;
        start[i] <= HI_W'(i * SPAN);
      end
      page_sh <= 5'd8;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_BANKS; i++)
        if (cfg_addr == CFG_AW'(i)) begin
          waits[i] <= cfg_wdata[WAIT_W-1:0];
          start[i] <= cfg_wdata[8 +: HI_W];
        end
      if (cfg_addr == CFG_AW'(NUM_BANKS)) page_sh <= cfg_wdata[4:0];
    end
  end

  always_comb begin
    dec = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (core_addr[ADDR_W-1 -: HI_W] >= start[i]) dec = NUM_BANKS'(1) << i;
  end

  always_comb begin
    wsel = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (sel_q[i]) wsel = waits[i];
  end

  assign page_now = core_addr >> page_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sel_q    <= '0;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      cnt      <= '0;
      ready_q  <= 1'b0;
      last_pg  <= '0;
      pg_valid <= 1'b0;
      cross_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      case (st)
        S_IDLE:
          if (core_req && !ready_q) begin
            st       <= S_SETUP;
            sel_q    <= dec;
            addr_q   <= core_addr;
            we_q     <= core_we;
            wdata_q  <= core_wdata;
            cross_q  <= !pg_valid || (page_now != last_pg);
            last_pg  <= page_now;
            pg_valid <= 1'b1;
          end
        S_SETUP:
          if (tri_req) st <= S_HOLD;
          else begin
            cnt <= wsel;
            st  <= S_STROBE;
          end
        S_STROBE:
          if (tri_req) st <= S_HOLD;
          else if (cnt != '0) cnt <= cnt - 1'b1;
          else if (mem_ack) begin
            st      <= S_IDLE;
            ready_q <= 1'b1;
            if (!we_q) rdata_q <= mem_din[BUS_W-1 -: DATA_W];
          end
        S_HOLD:
          if (!tri_req && mem_ack) begin
            cnt <= wsel;
            st  <= S_STROBE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy        = (st != S_IDLE);
  assign mem_addr    = addr_q;
  assign mem_addr_oe = !tri_req;
  assign mem_sel     = busy ? sel_q : '0;
  assign mem_rd      = (st == S_STROBE) && !we_q && !tri_req;
  assign mem_wr      = (st == S_STROBE) && we_q && !tri_req;
  assign mem_dout    = {wdata_q, {LANE{1'b0}}};
  assign mem_dout_en = mem_wr;
  assign mem_page    = busy && cross_q;
  assign core_ready  = ready_q;
  assign core_rdata  = rdata_q;
endmodule

// File: rtl/extmem_ctrl_chk.sv
module extmem_ctrl_chk #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] mem_sel,
  input logic                 mem_rd,
  input logic                 mem_wr,
  input logic                 mem_addr_oe,
  input logic                 mem_dout_en,
  input logic                 mem_ack,
  input logic                 tri_req,
  input logic                 core_ready
);
  p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_sel));

  p_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |-> (!mem_addr_oe && !mem_dout_en && !mem_rd && !mem_wr));

  p_no_finish_floated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tri_req |=> !core_ready);

  p_sel_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd || mem_wr) |-> $stable(mem_sel));

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |=> !core_ready);

  p_ready_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_ready |-> $past(mem_ack && (mem_rd || mem_wr)));
endmodule

bind extmem_ctrl extmem_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_sel(mem_sel), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr_oe(mem_addr_oe), .mem_dout_en(mem_dout_en),
  .mem_ack(mem_ack), .tri_req(tri_req), .core_ready(core_ready)
);

// File: tb/extmem_ctrl_bench.sv
module extmem_ctrl_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        core_req = 0, core_we = 0;
  logic [23:0] core_addr = '0;
  logic [31:0] core_wdata = '0, core_rdata;
  logic        core_ready;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [23:0] mem_addr;
  logic        mem_addr_oe, mem_rd, mem_wr, mem_dout_en, mem_page;
  logic [3:0]  mem_sel;
  logic [47:0] mem_dout, mem_din = '0;
  logic        mem_ack = 0, tri_req = 0;
  int errors = 0, checks = 0;

  extmem_ctrl u_extmem_ctrl (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic t_reset;
    chk(mem_sel == 0 && !mem_rd && !mem_wr && !mem_dout_en && !mem_page && !core_ready
        && mem_addr_oe, "R1", "idle outputs after reset",
        {mem_sel, mem_rd, mem_wr, mem_dout_en, mem_page, core_ready, mem_addr_oe}, 64'h1);
  endtask

  task automatic access(input bit we, input logic [23:0] a, input logic [31:0] wd,
                        input logic [31:0] rd_word, input logic [3:0] exp_sel,
                        input int w, input int extra, input bit exp_page,
                        input bit linger, input string req);
    int n = 0, guard = 0;
    @(negedge clk);
    core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
    mem_din = {rd_word, 16'hBEEF}; mem_ack = 0;
    @(negedge clk);
    chk(mem_sel == exp_sel, req, "bank select in setup", mem_sel, exp_sel);
    chk(!mem_rd && !mem_wr, "R3", "no strobe in setup cycle", {mem_rd, mem_wr}, 0);
    chk(mem_page == exp_page, "R6", "page flag", mem_page, exp_page);
    while (!core_ready && guard < 200) begin
      @(negedge clk); guard++;
      if (mem_rd || mem_wr) begin
        n++;
        mem_ack = (n >= w + 1 + extra);
        chk(!(mem_rd && mem_wr), "R10", "strobes exclusive", {mem_rd, mem_wr}, 0);
        chk(mem_dout_en == we, "R10", "data enable only on write", mem_dout_en, we);
        if (we) chk(mem_dout == {wd, 16'h0}, "R9", "write lane", mem_dout, {wd, 16'h0});
      end
    end
    chk(n == w + 1 + extra, extra > 0 ? "R5" : "R4", "strobe cycles", n, w + 1 + extra);
    if (!we) chk(core_rdata == rd_word, "R9", "read lane", core_rdata, rd_word);
    mem_ack = 0;
    if (!linger) core_req = 0;
    @(negedge clk);
    chk(!core_ready, "R11", "ready is one cycle", core_ready, 0);
    if (linger) begin
      chk(mem_sel == 0 && !mem_rd && !mem_wr, "R11", "no second accept",
          {mem_sel, mem_rd, mem_wr}, 0);
      core_req = 0;
    end
  endtask

  task automatic t_float;
    int n = 0, guard = 0;
    @(negedge clk);
    core_req = 1; core_we = 1; core_addr = 24'h8F0010; core_wdata = 32'h13579BDF;
    mem_ack = 1;
    @(negedge clk);
    @(negedge clk);
    chk(mem_wr, "R7", "write strobe before float", mem_wr, 1);
    tri_req = 1; #1;
    chk(!mem_addr_oe && !mem_wr && !mem_dout_en, "R7", "drivers released",
        {mem_addr_oe, mem_wr, mem_dout_en}, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!core_ready && !mem_wr, "R7", "frozen while floated", {core_ready, mem_wr}, 0);
    end
    tri_req = 0; mem_ack = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!core_ready && !mem_wr && mem_addr_oe, "R8", "waits for acknowledge",
          {core_ready, mem_wr, mem_addr_oe}, 1);
    end
    mem_ack = 1;
    while (!core_ready && guard < 200) begin
      @(negedge clk); guard++;
      if (mem_wr) n++;
    end
    chk(n == 4, "R8", "full strobe phase after resume", n, 4);
    core_req = 0; mem_ack = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    cfg_write(3'd0, 16'h0001);
    cfg_write(3'd1, 16'h4000);
    cfg_write(3'd2, 16'h8003);
    cfg_write(3'd3, 16'hC002);
    cfg_write(3'd4, 16'h0004);
    access(1, 24'h000010, 32'hA5A5_1234, 0, 4'b0001, 1, 0, 1, 0, "R2");
    access(0, 24'h000014, 0, 32'hCAFE_F00D, 4'b0001, 1, 0, 0, 0, "R2");
    access(0, 24'h000020, 0, 32'h1111_2222, 4'b0001, 1, 0, 1, 0, "R6");
    access(1, 24'h412345, 32'hDEAD_BEEF, 0, 4'b0010, 0, 2, 1, 0, "R2");
    access(0, 24'h8F0000, 0, 32'h0BAD_F00D, 4'b0100, 3, 0, 1, 0, "R4");
    access(1, 24'hC00000, 32'h0F0F_F0F0, 0, 4'b1000, 2, 3, 1, 0, "R5");
    cfg_write(3'd1, 16'hF000);
    access(0, 24'h500000, 0, 32'h5555_AAAA, 4'b0001, 1, 0, 1, 0, "R2");
    access(0, 24'hF10000, 0, 32'h7777_8888, 4'b1000, 2, 0, 1, 1, "R2");
    cfg_write(3'd0, 16'h1001);
    access(0, 24'h050000, 0, 32'h9999_0000, 4'b0000, 0, 0, 1, 0, "R2");
    access(0, 24'h050004, 0, 32'h9999_0001, 4'b0000, 0, 0, 0, 1, "R11");
    t_float;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule